// File: doc/BRIEF.md
# Broadcast SIMD Neuron MAC Array

A bank of multiply-accumulate lanes that computes the weighted sums of several neurons at once. Each clock the host stream may present one signed 16-bit sample; the same sample goes to every lane. Each lane multiplies it by a signed 8-bit weight from its own weight store and adds the product into a private 32-bit accumulator. All lanes read their stores at the same address. That address comes from a shared compute pointer, which steps once per accepted sample. Because the pointer's start value can be loaded, one array can hold the weights of several neurons or layers in separate address ranges.

A synchronous register port (chip select, write strobe, read strobe, 4-bit register address, 16-bit data) does all control. It loads weights through a sequential write pointer that is separate from the compute pointer. It clears the accumulators, copies them into per-lane output registers, picks the lane to read, and sets the scale applied on the read path. A result reaches the 16-bit bus only after an arithmetic right shift and saturation. A bypass mode hands the activation lookup-table address and data pins to the host, so the external table can be filled. A 4-bit auxiliary register drives the table's control pins.

Top module: `simd_mac_array`

## Requirements
- R1: After reset all accumulators, output registers, pointers, shift amount, auxiliary value and bypass flag are zero, so with the port selected for reading rdata_o, lut_addr_o and aux_o read 0.
- R2: A sample taken with din_valid_i high at clock edge k adds din_i times the weight at the compute address to every lane's accumulator, and the change is visible from edge k+3. Samples with din_valid_i low change nothing. Sums wrap modulo 2^32.
- R3: The compute address increments by one, modulo DEPTH, for every accepted sample. A host write to register 1 loads it from wdata_i, and this load takes priority over the increment.
- R4: A write to register 2 loads the sequential write pointer {lane, address}, with the lane in the upper bits. Each write to register 3 stores wdata_i[7:0] at that pointer and then advances it, moving through the addresses first and then the lanes, and wrapping to 0.
- R5: Writing code 1 to register 0 zeroes every accumulator. The clear takes precedence over a product arriving at the same edge.
- R6: Writing code 2 to register 0 copies every accumulator, as it stood before that edge, into its lane's output register.
- R7: A write to register 5 loads the output lane pointer. Code 3 written to register 0 increments it modulo LANES. The read path uses the output register of the selected lane.
- R8: Register 4 holds a shift amount. Values above 16 act as 16. The selected output is shifted arithmetically right by that amount and saturated to the range -32768..32767.
- R9: rdata_o carries the scaled result only while cs_ni and rd_ni are both low, and reads 0 otherwise. Writes take effect only when cs_ni and wr_ni are both low at a clock edge.
- R10: Register 8 bit 0 enables bypass. With bypass on, lut_addr_o shows the table pointer, and a write to register 9 raises lut_we_o in that cycle and then advances the pointer. With bypass off, lut_addr_o shows the scaled result and lut_we_o stays low. lut_data_o always mirrors wdata_i.
- R11: A write to register 6 loads the table pointer, and code 4 written to register 0 increments it. A write to register 7 sets aux_o from wdata_i[3:0].
- R12: Command codes other than 1 to 4, and writes to registers 10 to 15, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_valid_i | input | 1 | Sample valid |
| din_i | input | 16 | Broadcast sample, two's complement |
| cs_ni | input | 1 | Register port select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Scaled result of the selected lane |
| lut_addr_o | output | 16 | Lookup-table address |
| lut_data_o | output | 16 | Lookup-table write data |
| lut_we_o | output | 1 | Lookup-table write enable |
| aux_o | output | 4 | Auxiliary table control |

## Verification
The hardest case to reach is a clear command arriving in the same cycle as a product leaving the three-stage pipeline. That product must be dropped rather than added to the zeroed sum. The bench sends a lone sample and issues the clear exactly three edges later, then checks that a later sample starts a clean sum. It also loads the compute pointer two entries below the end of the store, so a burst wraps past the last address, and it sweeps the shift amount past 16 with extreme inputs so that both saturation limits are driven.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int HW = 16;  // host data width
  localparam int RW = 4;   // register address width

  localparam logic [RW-1:0] REG_CMD   = 4'd0;
  localparam logic [RW-1:0] REG_WPTR  = 4'd1;
  localparam logic [RW-1:0] REG_SPTR  = 4'd2;
  localparam logic [RW-1:0] REG_WDATA = 4'd3;
  localparam logic [RW-1:0] REG_SHIFT = 4'd4;
  localparam logic [RW-1:0] REG_OPTR  = 4'd5;
  localparam logic [RW-1:0] REG_LPTR  = 4'd6;
  localparam logic [RW-1:0] REG_AUX   = 4'd7;
  localparam logic [RW-1:0] REG_CFG   = 4'd8;
  localparam logic [RW-1:0] REG_LUTD  = 4'd9;

  localparam logic [3:0] CMD_CLR  = 4'd1;
  localparam logic [3:0] CMD_LOAD = 4'd2;
  localparam logic [3:0] CMD_OINC = 4'd3;
  localparam logic [3:0] CMD_LINC = 4'd4;
endpackage

// File: rtl/smac_lane.sv
module smac_lane #(
  parameter int DW     = 16,
  parameter int WW     = 8,
  parameter int AW     = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [WW-1:0]        wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  input  logic signed [DW-1:0] d_i,
  input  logic                 v_i,
  input  logic                 clr_i,
  input  logic                 ld_i,
  output logic [AW-1:0]        out_o
);
  localparam int PW = DW + WW;

  logic signed [WW-1:0] mem [DEPTH];
  logic signed [WW-1:0] w_q;
  logic signed [PW-1:0] p_q;
  logic [AW-1:0]        acc_q;
  logic [AW-1:0]        out_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      p_q   <= '0;
      acc_q <= '0;
      out_q <= '0;
    end else begin
      w_q <= mem[raddr_i];
      p_q <= d_i * w_q;
      if (clr_i)    acc_q <= '0;
      else if (v_i) acc_q <= acc_q + {{(AW-PW){p_q[PW-1]}}, p_q};
      if (ld_i) out_q <= acc_q;
    end
  end

  assign out_o = out_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
  // R6
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> out_q == $past(acc_q));
  // R2
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !v_i) |=> $stable(acc_q));
endmodule

// File: rtl/smac_scale.sv
module smac_scale #(
  parameter int IW = 32,
  parameter int OW = 16,
  parameter int SW = $clog2(OW + 1)
) (
  input  logic [IW-1:0] in_i,
  input  logic [SW-1:0] shamt_i,
  output logic [OW-1:0] out_o
);
  localparam logic signed [IW-1:0] MAXV = IW'((2 ** (OW - 1)) - 1);
  localparam logic signed [IW-1:0] MINV = -MAXV - 1;

  logic [SW-1:0]        eff;
  logic signed [IW-1:0] t;

  always_comb begin
    eff = (shamt_i > SW'(OW)) ? SW'(OW) : shamt_i;
    t   = $signed(in_i) >>> eff;
    if (t > MAXV)      out_o = MAXV[OW-1:0];
    else if (t < MINV) out_o = MINV[OW-1:0];
    else               out_o = t[OW-1:0];
  end
endmodule

// File: rtl/simd_mac_array.sv
module simd_mac_array
  import smac_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int WW    = 8,
  parameter int AW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          din_valid_i,
  input  logic [DW-1:0] din_i,
  input  logic          cs_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [RW-1:0] addr_i,
  input  logic [HW-1:0] wdata_i,
  output logic [HW-1:0] rdata_o,
  output logic [HW-1:0] lut_addr_o,
  output logic [HW-1:0] lut_data_o,
  output logic          lut_we_o,
  output logic [3:0]    aux_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LANE_W = $clog2(LANES);
  localparam int SPW    = LANE_W + ADDR_W;
  localparam int SW     = $clog2(HW + 1);

  logic              hw;
  logic [3:0]        cmd;
  logic              clr, ld, wptr_ld, seq_we;
  logic [ADDR_W-1:0] wptr_q, a1_q;
  logic [SPW-1:0]    sptr_q;
  logic [SW-1:0]     shamt_q;
  logic [LANE_W-1:0] optr_q;
  logic [HW-1:0]     lptr_q;
  logic [3:0]        aux_q;
  logic              byp_q;
  logic              v1_q, v2_q, v3_q;
  logic [DW-1:0]     d1_q, d2_q;
  logic [AW-1:0]     lane_out [LANES];
  logic [HW-1:0]     scaled;

  assign hw      = !cs_ni && !wr_ni;
  assign cmd     = wdata_i[3:0];
  assign clr     = hw && addr_i == REG_CMD && cmd == CMD_CLR;
  assign ld      = hw && addr_i == REG_CMD && cmd == CMD_LOAD;
  assign wptr_ld = hw && addr_i == REG_WPTR;
  assign seq_we  = hw && addr_i == REG_WDATA;

  // broadcast pipeline and pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0; a1_q <= '0;
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0;
      d1_q <= '0; d2_q <= '0;
      sptr_q <= '0; shamt_q <= '0; optr_q <= '0;
      lptr_q <= '0; aux_q <= '0; byp_q <= 1'b0;
    end else begin
      v1_q <= din_valid_i; d1_q <= din_i; a1_q <= wptr_q;
      v2_q <= v1_q;        d2_q <= d1_q;
      v3_q <= v2_q;
      if (wptr_ld)          wptr_q <= wdata_i[ADDR_W-1:0];
      else if (din_valid_i) wptr_q <= wptr_q + 1'b1;
      if (hw) begin
        unique case (addr_i)
          REG_SPTR:  sptr_q  <= wdata_i[SPW-1:0];
          REG_WDATA: sptr_q  <= sptr_q + 1'b1;
          REG_SHIFT: shamt_q <= wdata_i[SW-1:0];
          REG_OPTR:  optr_q  <= wdata_i[LANE_W-1:0];
          REG_LPTR:  lptr_q  <= wdata_i;
          REG_AUX:   aux_q   <= wdata_i[3:0];
          REG_CFG:   byp_q   <= wdata_i[0];
          REG_LUTD:  if (byp_q) lptr_q <= lptr_q + 1'b1;
          REG_CMD: begin
            if (cmd == CMD_OINC) optr_q <= optr_q + 1'b1;
            if (cmd == CMD_LINC) lptr_q <= lptr_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    smac_lane #(.DW(DW), .WW(WW), .AW(AW), .DEPTH(DEPTH)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (seq_we && sptr_q[SPW-1:ADDR_W] == LANE_W'(g)),
      .waddr_i (sptr_q[ADDR_W-1:0]),
      .wdata_i (wdata_i[WW-1:0]),
      .raddr_i (a1_q),
      .d_i     (d2_q),
      .v_i     (v3_q),
      .clr_i   (clr),
      .ld_i    (ld),
      .out_o   (lane_out[g])
    );
  end

  smac_scale #(.IW(AW), .OW(HW), .SW(SW)) u_scale (
    .in_i    (lane_out[optr_q]),
    .shamt_i (shamt_q),
    .out_o   (scaled)
  );

  assign rdata_o    = (!cs_ni && !rd_ni) ? scaled : '0;
  assign lut_addr_o = byp_q ? lptr_q : scaled;
  assign lut_data_o = wdata_i;
  assign lut_we_o   = byp_q && hw && addr_i == REG_LUTD;
  assign aux_o      = aux_q;

  // R3
  wptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_valid_i && !wptr_ld) |=> wptr_q == $past(wptr_q) + 1'b1);
  // R12
  undef_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw && addr_i > REG_LUTD) |=> ($stable(sptr_q) && $stable(shamt_q) &&
      $stable(optr_q) && $stable(lptr_q) && $stable(aux_q) && $stable(byp_q)));
  // R8
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && shamt_q == '0 &&
     $signed(lane_out[optr_q]) <= 32767 && $signed(lane_out[optr_q]) >= -32768)
    |-> rdata_o == lane_out[optr_q][HW-1:0]);
  // R9
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> rdata_o == '0);
endmodule

// File: tb/simd_mac_array_bench.sv
module simd_mac_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din_valid = 1'b0;
  logic [15:0] din = '0;
  logic        cs_n = 1'b0, wr_n = 1'b1, rd_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, lut_addr, lut_data;
  logic        lut_we;
  logic [3:0]  aux;

  int    n_tests = 0, n_fail = 0;
  bit    done = 0, chk_en = 0;
  string tag = "R1";

  simd_mac_array u_simd_mac_array (
    .clk_i(clk), .rst_ni(rst_n), .din_valid_i(din_valid), .din_i(din),
    .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .lut_addr_o(lut_addr), .lut_data_o(lut_data),
    .lut_we_o(lut_we), .aux_o(aux)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  typedef struct { bit v; int d; int a; } ent_t;
  ent_t pipe[$];
  int m_mem [LANES][DEPTH];
  int m_acc [LANES];
  int m_out [LANES];
  int m_wptr, m_sptr, m_sh, m_optr, m_lptr, m_aux, m_byp;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe.delete();
      for (int l = 0; l < LANES; l++) begin m_acc[l] = 0; m_out[l] = 0; end
      m_wptr = 0; m_sptr = 0; m_sh = 0; m_optr = 0; m_lptr = 0; m_aux = 0; m_byp = 0;
    end else begin
      bit   h;
      int   wd, c;
      ent_t e;
      h  = !cs_n && !wr_n;
      wd = int'(wdata);
      c  = wd & 15;
      e.v = 0; e.d = 0; e.a = 0;
      if (pipe.size() == 3) e = pipe.pop_front();
      for (int l = 0; l < LANES; l++) begin
        if (h && addr == 0 && c == 2) m_out[l] = m_acc[l];
        if (h && addr == 0 && c == 1) m_acc[l] = 0;
        else if (e.v) m_acc[l] = m_acc[l] + e.d * m_mem[l][e.a];
      end
      pipe.push_back('{din_valid, int'($signed(din)), m_wptr});
      if (h && addr == 1) m_wptr = wd % DEPTH;
      else if (din_valid) m_wptr = (m_wptr + 1) % DEPTH;
      if (h) begin
        case (addr)
          0: begin
            if (c == 3) m_optr = (m_optr + 1) % LANES;
            if (c == 4) m_lptr = (m_lptr + 1) % 65536;
          end
          2: m_sptr = wd % (LANES * DEPTH);
          3: begin
            m_mem[m_sptr / DEPTH][m_sptr % DEPTH] = int'($signed(wdata[7:0]));
            m_sptr = (m_sptr + 1) % (LANES * DEPTH);
          end
          4: m_sh = wd & 31;
          5: m_optr = wd % LANES;
          6: m_lptr = wd;
          7: m_aux = wd & 15;
          8: m_byp = wd & 1;
          9: if (m_byp != 0) m_lptr = (m_lptr + 1) % 65536;
          default: ;
        endcase
      end
    end
  end

  function automatic int scale(int v, int sh);
    int s, t;
    s = (sh > 16) ? 16 : sh;
    t = v >>> s;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t & 16'hFFFF;
  endfunction

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (chk_en && !done) begin
      int sc, er, ea, ew;
      sc = scale(m_out[m_optr], m_sh);
      er = (!cs_n && !rd_n) ? sc : 0;
      ea = m_byp ? m_lptr : sc;
      ew = (m_byp != 0 && !cs_n && !wr_n && addr == 9) ? 1 : 0;
      n_tests++;
      if (int'(rdata) != er || int'(lut_addr) != ea || int'(lut_we) != ew ||
          lut_data != wdata || int'(aux) != m_aux) begin
        n_fail++;
        $display("FAIL %s rdata=%h/%h lut_addr=%h/%h we=%0d/%0d ldata=%h/%h aux=%h/%h (actual/expected)",
                 tag, rdata, er[15:0], lut_addr, ea[15:0], lut_we, ew, lut_data, wdata, aux, m_aux[3:0]);
      end
    end
  end

  task automatic step(bit v, int d, bit w, int a, int wd);
    @(negedge clk);
    din_valid = v; din = d[15:0];
    wr_n = !w; addr = a[3:0]; wdata = wd[15:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic hwr(int a, int wd);
    step(0, 0, 1, a, wd);
  endtask

  function automatic int wgt(int l, int a);
    return ((l * 53 + a * 29 + 7) & 255);
  endfunction

  function automatic int smp(int i);
    if (i == 0) return -32768;
    if (i == 1) return 32767;
    return ((i * 4099) % 65536) - 32768;
  endfunction

  task automatic show_lanes();
    hwr(5, 0);
    for (int s = 0; s < 4; s++) begin
      hwr(4, (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 23);
      for (int l = 0; l < LANES; l++) hwr(0, 3);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired in %s", tag);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1;
    tag = "R1"; idle(3);

    tag = "R4"; hwr(2, 0);
    for (int i = 0; i < LANES * DEPTH; i++) hwr(3, wgt(i / DEPTH, i % DEPTH));
    hwr(2, 2 * DEPTH + 5); hwr(3, 8'h7F); hwr(3, 8'h80);

    tag = "R2"; hwr(1, 0); hwr(0, 1);
    for (int i = 0; i < 24; i++) step((i % 5) != 4, smp(i), 0, 0, 0);
    idle(3);
    tag = "R6"; hwr(0, 2);
    tag = "R8"; show_lanes();

    tag = "R3"; hwr(0, 1); hwr(1, DEPTH - 2);
    for (int i = 0; i < 5; i++) step(1, smp(i + 7), 0, 0, 0);
    step(1, 1000, 1, 1, 3);
    idle(4); hwr(0, 2);
    tag = "R7"; hwr(5, 6); hwr(0, 3); hwr(0, 3); hwr(0, 3); hwr(4, 0);

    tag = "R5"; hwr(0, 1);
    step(1, 20000, 0, 0, 0); idle(2); hwr(0, 1);
    step(1, -300, 0, 0, 0); idle(3); hwr(0, 2);
    show_lanes();
    hwr(0, 1);
    for (int i = 0; i < 6; i++) step(1, smp(i + 30), 0, 0, 0);
    hwr(0, 1); idle(4); hwr(0, 2); show_lanes();

    tag = "R12"; hwr(0, 7); hwr(0, 0); hwr(0, 15); hwr(12, 16'hFFFF); hwr(15, 5); idle(2);

    tag = "R9"; @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 4; wdata = 3;
    @(negedge clk); addr = 8; wdata = 1;
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    idle(2); rd_n = 1'b0; idle(1);

    tag = "R10"; hwr(6, 16'h0100); hwr(8, 1); hwr(9, 16'h1234); hwr(9, 16'hBEEF);
    idle(1); hwr(9, 16'h0042);
    tag = "R11"; hwr(0, 4); hwr(7, 16'hFFFA); hwr(6, 16'hFFFF); hwr(0, 4);
    tag = "R10"; hwr(8, 0); hwr(9, 16'h5555); idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule